// File: doc/BRIEF.md
# I2C Register Access Slave

This block is a two-wire serial slave that lets a host controller read and write an 8-bit register bank of 64 locations. The bus wires are sampled on the system clock, so the slave sees SCL and SDA only as input values. It pulls SDA low through a single output-enable: a high enable means the pad is driven low, and a low enable means the pad is released to the pull-up. The register bank itself lives outside the block and is reached through a simple register bus. That bus carries an address, write data with a write strobe, a fetch strobe, and read data that arrives combinationally for the presented address.

The seven-bit device address has five zero bits at the top and two strap pins at the bottom. The strap pattern 00 disables the slave entirely. After the device address in write direction, the host sends one word-address byte. Data bytes then land at successive locations. A read, started either through a repeated START or through a fresh START, returns bytes from the stored word address onward. The pointer advances after every byte in either direction and is kept across a repeated START.

Writing the key value 0x96 to location 0x3C raises a one-cycle "restore defaults" strobe. The same key written to 0x3D raises a one-cycle "calibrate oscillators" strobe.

Top module: `i2c_regslv`

## Requirements
- R1: After reset, and in the cycles following a STOP (SDA rising while SCL is high), the slave releases SDA (sda_drive_low = 0) and issues no register strobe.
- R2: When strap_i is nonzero and the seven bits after START equal {5'b00000, strap_i[1], strap_i[0]}, the slave pulls SDA low during the ninth clock (acknowledge). The eighth bit selects the direction: 0 for write, 1 for read.
- R3: A device address that does not match gets no acknowledge. The slave then ignores every byte until the next START: it gives no acknowledge and issues no register write.
- R4: With strap_i = 2'b00 the slave acknowledges no address at all.
- R5: In a write, the first byte after the address is the word address (its low 6 bits are used). Every later byte is acknowledged and produces one reg_we pulse, with reg_addr set to the pointer and reg_wdata set to the byte.
- R6: The word-address pointer increments by one after every byte written or read, and wraps from 0x3F to 0x00.
- R7: A repeated START followed by the read address returns data starting at the word address set in the preceding write phase.
- R8: A read opened by a fresh START continues from the current pointer, as left by earlier transfers.
- R9: A host acknowledge after a read byte makes the slave send the next location. After a host NACK the slave releases SDA and does not drive it again until a START.
- R10: A write of 0x96 to address 0x3C pulses cmd_pulse[0] for one cycle, and a write of 0x96 to 0x3D pulses cmd_pulse[1]. Any other value or address pulses neither.
- R11: SDA is pulled low only during acknowledge bits and during 0-bits of read data, which are sent MSB first. It never changes while SCL is high, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL wire |
| sda_i | input | 1 | Sampled level of the SDA wire |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 2 | Device-address strap pins (low two address bits) |
| reg_addr | output | 6 | Register bus address (current word pointer) |
| reg_wdata | output | 8 | Register bus write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register fetch strobe |
| reg_rdata | input | 8 | Register bus read data for reg_addr |
| cmd_pulse | output | 2 | Direct-command strobes: bit 0 restore defaults, bit 1 calibrate |

## Verification
A wrong pointer shows at the next data byte. A write lands at the wrong location of the bench's bank model, and a read returns a value that does not match the bench's expected image. The full 64-location sweeps in both directions make every wrap and skip visible within one transfer. A slip in the bit or state sequencing shows within a byte, as a missing or misplaced acknowledge or as a shifted read byte. Stale drive after a NACK shows in the very next byte clocked with the host released.

// File: rtl/i2c_regslv_pkg.sv
package i2c_regslv_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WA,
      ST_WR,
      ST_ACK,
      ST_RD,
      ST_RACK,
      ST_WAIT
   } slv_state_t;

   localparam int unsigned BUS_BYTE_W = 8;
   localparam int unsigned DEV_ADDR_W = 7;

endpackage

// File: rtl/i2c_regslv_sync.sv
module i2c_regslv_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_regslv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_q     <= 1'b1;
         sda_q     <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[STAGES-2:0], scl_in};
         sda_chain <= {sda_chain[STAGES-2:0], sda_in};
         scl_q     <= scl_s;
         sda_q     <= sda_s;
      end
   end

   assign scl_s     = scl_chain[STAGES-1];
   assign sda_s     = sda_chain[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_regslv_addr.sv
module i2c_regslv_addr #(
   parameter int unsigned DEV_W   = 7,
   parameter int unsigned STRAP_W = 2
) (
   input  logic [DEV_W-1:0]   dev_field,
   input  logic [STRAP_W-1:0] strap,
   output logic               hit
);

   localparam int unsigned HI_W = DEV_W - STRAP_W;

   generate
      if (STRAP_W >= DEV_W) begin : g_bad_strap
         $error("i2c_regslv_addr: STRAP_W must be below DEV_W");
      end
   endgenerate

   logic strap_legal;

   assign strap_legal = (strap != '0);
   assign hit = strap_legal && (dev_field == {{HI_W{1'b0}}, strap});

endmodule

// File: rtl/i2c_regslv_cmd.sv
module i2c_regslv_cmd #(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_CMDS = 2,
   parameter int unsigned CMD_BASE = 60,
   parameter int unsigned CMD_KEY  = 150
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   data,
   output logic [NUM_CMDS-1:0] pulse
);

   generate
      if (CMD_BASE + NUM_CMDS > (1 << ADDR_W)) begin : g_bad_base
         $error("i2c_regslv_cmd: command window exceeds address space");
      end
   endgenerate

   logic key_seen;
   assign key_seen = we && (data == DATA_W'(CMD_KEY));

   for (genvar i = 0; i < NUM_CMDS; i++) begin : g_cmd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pulse[i] <= 1'b0;
         end else begin
            pulse[i] <= key_seen && (addr == ADDR_W'(CMD_BASE + i));
         end
      end
   end

   // R10: at most one command strobe at a time
   p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pulse));

   // R10: a command strobe only follows a register write
   p_cmd_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse != '0) |-> $past(we));

   // R10: command strobes last a single cycle
   p_cmd_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse != '0) |=> (pulse == '0));

endmodule

// File: rtl/i2c_regslv.sv
module i2c_regslv
   import i2c_regslv_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned STRAP_W     = 2,
   parameter int unsigned NUM_CMDS    = 2,
   parameter int unsigned CMD_BASE    = 60,
   parameter int unsigned CMD_KEY     = 150
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   output logic                sda_drive_low,
   input  logic [STRAP_W-1:0]  strap_i,
   output logic [ADDR_W-1:0]   reg_addr,
   output logic [DATA_W-1:0]   reg_wdata,
   output logic                reg_we,
   output logic                reg_re,
   input  logic [DATA_W-1:0]   reg_rdata,
   output logic [NUM_CMDS-1:0] cmd_pulse
);

   localparam int unsigned CNT_W = $clog2(DATA_W + 1);
   localparam int unsigned MSB   = DATA_W - 1;

   generate
      if (DATA_W != BUS_BYTE_W) begin : g_bad_data
         $error("i2c_regslv: DATA_W must equal the bus byte width");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("i2c_regslv: ADDR_W must fit in one word-address byte");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic dev_hit;

   slv_state_t          state;
   slv_state_t          ack_next;
   logic [DATA_W-1:0]   shreg;
   logic [CNT_W-1:0]    bitcnt;
   logic [ADDR_W-1:0]   wptr;
   logic                host_ack;

   i2c_regslv_sync #(
      .STAGES    (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_i),
      .sda_in    (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_regslv_addr #(
      .DEV_W     (DEV_ADDR_W),
      .STRAP_W   (STRAP_W)
   ) u_addr (
      .dev_field (shreg[DATA_W-1:1]),
      .strap     (strap_i),
      .hit       (dev_hit)
   );

   i2c_regslv_cmd #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_CMDS  (NUM_CMDS),
      .CMD_BASE  (CMD_BASE),
      .CMD_KEY   (CMD_KEY)
   ) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .addr      (reg_addr),
      .data      (reg_wdata),
      .pulse     (cmd_pulse)
   );

   assign reg_addr = wptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         ack_next      <= ST_IDLE;
         shreg         <= '0;
         bitcnt        <= '0;
         wptr          <= '0;
         host_ack      <= 1'b0;
         sda_drive_low <= 1'b0;
         reg_we        <= 1'b0;
         reg_re        <= 1'b0;
         reg_wdata     <= '0;
      end else begin
         reg_we <= 1'b0;
         reg_re <= 1'b0;
         if (reg_we) begin
            wptr <= wptr + 1'b1;
         end
         if (stop_det) begin
            state         <= ST_IDLE;
            sda_drive_low <= 1'b0;
         end else if (start_det) begin
            state         <= ST_DEV;
            bitcnt        <= '0;
            sda_drive_low <= 1'b0;
         end else begin
            case (state)
               ST_DEV, ST_WA, ST_WR: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[DATA_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == CNT_W'(DATA_W)) begin
                     bitcnt <= '0;
                     if (state == ST_DEV) begin
                        if (dev_hit) begin
                           sda_drive_low <= 1'b1;
                           state         <= ST_ACK;
                           ack_next      <= shreg[0] ? ST_RD : ST_WA;
                        end else begin
                           state <= ST_WAIT;
                        end
                     end else if (state == ST_WA) begin
                        wptr          <= shreg[ADDR_W-1:0];
                        sda_drive_low <= 1'b1;
                        state         <= ST_ACK;
                        ack_next      <= ST_WR;
                     end else begin
                        reg_we        <= 1'b1;
                        reg_wdata     <= shreg;
                        sda_drive_low <= 1'b1;
                        state         <= ST_ACK;
                        ack_next      <= ST_WR;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     state  <= ack_next;
                     if (ack_next == ST_RD) begin
                        shreg         <= reg_rdata;
                        reg_re        <= 1'b1;
                        sda_drive_low <= ~reg_rdata[MSB];
                     end else begin
                        sda_drive_low <= 1'b0;
                     end
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (bitcnt == CNT_W'(DATA_W - 1)) begin
                        sda_drive_low <= 1'b0;
                        state         <= ST_RACK;
                        wptr          <= wptr + 1'b1;
                     end else begin
                        shreg         <= {shreg[DATA_W-2:0], 1'b0};
                        sda_drive_low <= ~shreg[DATA_W-2];
                        bitcnt        <= bitcnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        shreg         <= reg_rdata;
                        reg_re        <= 1'b1;
                        sda_drive_low <= ~reg_rdata[MSB];
                        bitcnt        <= '0;
                        state         <= ST_RD;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R1: a STOP leaves the line released
   p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_drive_low);

   // R4: an acknowledge raised from address decode needs a legal strap
   p_strap_zero_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_drive_low) && $past(state) == ST_DEV) |-> ($past(strap_i) != '0));

   // R5: write and fetch strobes never overlap
   p_bus_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));

   // R6: the pointer moves by exactly one after each write, wrapping
   p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

   // R9: after a NACK the slave stays released until a START
   p_nack_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> !sda_drive_low);

   // R11: SDA drive only changes with SCL low or at START/STOP release
   p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> (!scl_s || (!sda_drive_low && $past(start_det || stop_det))));

endmodule

// File: tb/i2c_regslv_test.sv
`timescale 1ns/1ps
module i2c_regslv_test;

   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_host = 1'b1;
   logic       sda_bus;
   logic       sda_drive_low;
   logic [1:0] strap = 2'b00;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_we;
   logic       reg_re;
   logic [7:0] reg_rdata;
   logic [1:0] cmd_pulse;

   logic [7:0] bank    [64];
   logic [7:0] exp_img [64];
   int checks = 0;
   int errors = 0;
   int we_cnt = 0;
   int preset_cnt = 0;
   int calib_cnt = 0;
   logic oe_bad = 1'b0;
   logic [6:0] dev;

   always #2 clk = ~clk;

   assign sda_bus   = sda_host & ~sda_drive_low;
   assign reg_rdata = bank[reg_addr];

   i2c_regslv uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl),
      .sda_i         (sda_bus),
      .sda_drive_low (sda_drive_low),
      .strap_i       (strap),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_we        (reg_we),
      .reg_re        (reg_re),
      .reg_rdata     (reg_rdata),
      .cmd_pulse     (cmd_pulse)
   );

   always @(posedge clk) begin
      if (reg_we) begin
         bank[reg_addr] <= reg_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (cmd_pulse[0]) preset_cnt <= preset_cnt + 1;
      if (cmd_pulse[1]) calib_cnt  <= calib_cnt + 1;
   end

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bit_out(input logic b);
      sda_host = b;
      wait_clk(Q);
      scl = 1'b1;
      wait_clk(Q);
      if (sda_drive_low) oe_bad = 1'b1;
      wait_clk(Q);
      scl = 1'b0;
      wait_clk(Q);
   endtask

   task automatic bit_in(output logic b);
      sda_host = 1'b1;
      wait_clk(Q);
      scl = 1'b1;
      wait_clk(Q);
      b = sda_bus;
      wait_clk(Q);
      scl = 1'b0;
      wait_clk(Q);
   endtask

   task automatic bus_start();
      sda_host = 1'b1;
      wait_clk(Q);
      scl = 1'b1;
      wait_clk(Q);
      sda_host = 1'b0;
      wait_clk(Q);
      scl = 1'b0;
      wait_clk(Q);
   endtask

   task automatic bus_stop();
      sda_host = 1'b0;
      wait_clk(Q);
      scl = 1'b1;
      wait_clk(Q);
      sda_host = 1'b1;
      wait_clk(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(a);
      acked = ~a;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         d[i] = b;
      end
      bit_out(~give_ack);
   endtask

   task automatic write_burst(input logic [5:0] wa, input int n,
                              input logic [7:0] first, input logic [7:0] step);
      logic ack;
      logic [7:0] d;
      bus_start();
      send_byte({dev, 1'b0}, ack);
      chk("R2 write address ack", ack, 1'b1);
      send_byte({2'b00, wa}, ack);
      chk("R5 word address ack", ack, 1'b1);
      for (int k = 0; k < n; k++) begin
         d = first + 8'(k) * step;
         send_byte(d, ack);
         chk("R5 data ack", ack, 1'b1);
         exp_img[6'(wa + 6'(k))] = d;
      end
      bus_stop();
      wait_clk(4);
      for (int k = 0; k < n; k++) begin
         chk("R6 written location", bank[6'(wa + 6'(k))], exp_img[6'(wa + 6'(k))]);
      end
   endtask

   task automatic read_random(input logic [5:0] wa, input int n, input string tag);
      logic ack;
      logic [7:0] d;
      bus_start();
      send_byte({dev, 1'b0}, ack);
      send_byte({2'b00, wa}, ack);
      bus_start();
      send_byte({dev, 1'b1}, ack);
      chk("R7 read address ack", ack, 1'b1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, d);
         chk(tag, d, exp_img[6'(wa + 6'(k))]);
      end
      bus_stop();
   endtask

   task automatic read_fresh(input logic [5:0] from, input int n, input string tag);
      logic ack;
      logic [7:0] d;
      bus_start();
      send_byte({dev, 1'b1}, ack);
      chk("R8 fresh read ack", ack, 1'b1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, d);
         chk(tag, d, exp_img[6'(from + 6'(k))]);
      end
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic ack;
      logic ack2;
      logic [7:0] d;
      int we_before;
      int pre_before;
      int cal_before;

      for (int i = 0; i < 64; i++) begin
         bank[i]    = 8'(i * 7 + 3);
         exp_img[i] = 8'(i * 7 + 3);
      end
      wait_clk(10);
      rst_n = 1'b1;
      wait_clk(4);
      chk("R1 reset drive", sda_drive_low, 1'b0);
      chk("R1 reset write strobe", reg_we, 1'b0);
      chk("R10 reset commands", cmd_pulse, 2'b00);

      // R2 R3 R4: sweep of straps against candidate device addresses
      for (int s = 0; s < 4; s++) begin
         strap = 2'(s);
         for (int a = 0; a < 9; a++) begin
            logic [6:0] cand;
            logic expect_ack;
            cand = (a == 8) ? 7'h41 : 7'(a);
            expect_ack = (s != 0) && (cand == 7'(s));
            we_before = we_cnt;
            bus_start();
            send_byte({cand, 1'b0}, ack);
            if (s == 0) chk("R4 forbidden strap", ack, 1'b0);
            else if (expect_ack) chk("R2 address match", ack, 1'b1);
            else begin
               chk("R3 address mismatch", ack, 1'b0);
               send_byte(8'h05, ack2);
               chk("R3 ignored byte", ack2, 1'b0);
               wait_clk(4);
               chk("R3 no write", we_cnt, we_before);
            end
            bus_stop();
            wait_clk(4);
            chk("R1 released after stop", sda_drive_low, 1'b0);
         end
      end

      strap = 2'b10;
      dev   = 7'h02;

      // R5 R6: burst crossing the top of the address space
      write_burst(6'h3E, 3, 8'h5A, 8'h35);
      // R7: random read through repeated start across the wrap
      read_random(6'h3E, 3, "R7 random read");
      // R8: fresh start continues after the three reads (3E,3F,00 -> 01)
      read_fresh(6'h01, 1, "R8 fresh read after read");
      // R8: pointer left by a write burst
      write_burst(6'h10, 2, 8'h11, 8'h11);
      read_fresh(6'h12, 1, "R8 fresh read after write");

      // R9: after NACK the slave stays off the line
      bus_start();
      send_byte({dev, 1'b1}, ack);
      recv_byte(1'b0, d);
      chk("R9 byte before nack", d, exp_img[6'h13]);
      recv_byte(1'b0, d);
      chk("R9 released after nack", d, 8'hFF);
      chk("R9 no drive after nack", sda_drive_low, 1'b0);
      bus_stop();

      // R9 R11: full sequential read of the whole space
      read_random(6'h00, 64, "R9 sequential read");
      // R6: pointer wrapped back to 0 after 64 reads
      read_fresh(6'h00, 1, "R6 read wrap");

      // R5 R10: full write sweep with no key values at the command slots
      pre_before = preset_cnt;
      cal_before = calib_cnt;
      write_burst(6'h20, 64, 8'hA1, 8'h0D);
      chk("R10 no restore on other data", preset_cnt, pre_before);
      chk("R10 no calibrate on other data", calib_cnt, cal_before);
      read_random(6'h20, 64, "R11 read back sweep");

      // R10: key value at the command slots
      write_burst(6'h3C, 1, 8'h96, 8'h00);
      wait_clk(4);
      chk("R10 restore strobe", preset_cnt, pre_before + 1);
      chk("R10 no calibrate", calib_cnt, cal_before);
      write_burst(6'h3C, 2, 8'h96, 8'h00);
      wait_clk(4);
      chk("R10 restore second", preset_cnt, pre_before + 2);
      chk("R10 calibrate strobe", calib_cnt, cal_before + 1);
      write_burst(6'h3B, 1, 8'h96, 8'h00);
      write_burst(6'h3C, 1, 8'h95, 8'h00);
      wait_clk(4);
      chk("R10 key elsewhere ignored", preset_cnt, pre_before + 2);
      chk("R10 wrong key ignored", calib_cnt, cal_before + 1);

      chk("R11 no drive during host bits", oe_bad, 1'b0);
      wait_clk(10);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule